// File: doc/BRIEF.md
# Six-Register Core with a Bindable Instruction Pointer

This block is a small sequential processor for a fixed set of sixteen three-operand operations. It holds six 32-bit general registers and a separate instruction pointer. Each instruction carries an opcode and three fields A, B and C. The instruction comes from an internal program store, which is filled through a write port before a run. The core retires one instruction per clock, writes the result to register C and then advances the instruction pointer.

A start pulse samples a binding choice, which is either no binding or one of the six registers. The binding holds for the whole run. When the pointer is bound, the bound register receives the pointer value before every instruction, and the pointer is reloaded from that register afterwards. Ordinary arithmetic on the bound register therefore acts as a jump. A run ends when the pointer leaves the program length that was latched at start. The core then raises a halt flag and freezes its state. All six registers and the pointer are visible at the ports.

Top module: `bip_core`

## Requirements
- R1: After reset, all six registers and the instruction pointer are zero, and both `halted` and `running` are low.
- R2: A `start` pulse while not running clears all registers and the pointer. It latches `bind_en`, `bind_sel` and `prog_len` and raises `running` on the next edge. A `start` pulse while running is ignored, and so are later changes to the binding inputs.
- R3: Opcodes 0 to 3 are add-register, add-immediate, multiply-register and multiply-immediate. They compute rC = rA + rB, rA + B, rA * rB and rA * B respectively. All values are unsigned, the literal B is zero-extended from 16 bits, and a product keeps its low 32 bits.
- R4: Opcodes 4 to 7 are AND-register, AND-immediate, OR-register and OR-immediate. They compute the bitwise rA & rB, rA & B, rA | rB and rA | B into rC.
- R5: Opcode 8 copies rA into rC, and opcode 9 writes the literal A into rC. Field B has no effect in either.
- R6: Opcodes 10, 11 and 12 write 1 into rC when A > rB, rA > B or rA > rB respectively (unsigned), and 0 otherwise.
- R7: Opcodes 13, 14 and 15 write 1 into rC when A == rB, rA == B or rA == rB respectively, and 0 otherwise.
- R8: With no binding, one instruction executes on each clock edge and the pointer rises by one per instruction.
- R9: With a binding, the bound register is loaded with the pointer before each instruction. Reads of that register see the pointer value. The new pointer is the bound register's value after the instruction, plus one.
- R10: When the pointer is not below the latched program length, `halted` rises on the next edge and `running` falls. From then on, registers and pointer stay unchanged until the next start.
- R11: A register field value above 5 reads as zero. A write whose C field is above 5 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from instruction zero |
| bind_en | input | 1 | Bind the pointer to a register for the next run |
| bind_sel | input | 3 | Register chosen for binding (0 to 5) |
| prog_len | input | AW+1 | Number of valid instructions for the next run |
| ld_we | input | 1 | Program store write enable |
| ld_addr | input | AW | Program store write address |
| ld_op | input | 4 | Opcode to store |
| ld_a | input | 16 | Field A to store |
| ld_b | input | 16 | Field B to store |
| ld_c | input | 16 | Field C to store |
| halted | output | 1 | Run finished |
| running | output | 1 | Run in progress |
| ip | output | 32 | Instruction pointer |
| regs_flat | output | 192 | Six registers, register k at bits 32k+31:32k |

## Verification
The edge that samples `start` clears the state. Each later edge retires one instruction, so a run of S retired instructions shows `halted` exactly S+1 edges after the start edge. Register and pointer values are final at that point. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge until `halted` is seen, and compares that count with S+1, where S comes from its own step model. It also compares all registers and the pointer with that model. The frozen state is checked again a few cycles later, and a start pulse given mid-run must leave both the cycle count and the results unchanged.

// File: rtl/bip_pkg.sv
package bip_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 6;
  localparam int FW   = 16;
  localparam int SW   = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_ADDR, OP_ADDI, OP_MULR, OP_MULI,
    OP_BANR, OP_BANI, OP_BORR, OP_BORI,
    OP_SETR, OP_SETI, OP_GTIR, OP_GTRI,
    OP_GTRR, OP_EQIR, OP_EQRI, OP_EQRR
  } op_e;

  typedef struct packed {
    op_e           opc;
    logic [FW-1:0] fa;
    logic [FW-1:0] fb;
    logic [FW-1:0] fc;
  } instr_t;

  // Result of one operation; ra/rb are register reads, ia/ib literals.
  function automatic logic [XLEN-1:0] op_eval(op_e op,
      logic [XLEN-1:0] ra, logic [XLEN-1:0] rb,
      logic [XLEN-1:0] ia, logic [XLEN-1:0] ib);
    logic [XLEN-1:0] r;
    case (op)
      OP_ADDR: r = ra + rb;
      OP_ADDI: r = ra + ib;
      OP_MULR: r = ra * rb;
      OP_MULI: r = ra * ib;
      OP_BANR: r = ra & rb;
      OP_BANI: r = ra & ib;
      OP_BORR: r = ra | rb;
      OP_BORI: r = ra | ib;
      OP_SETR: r = ra;
      OP_SETI: r = ia;
      OP_GTIR: r = XLEN'(ia > rb);
      OP_GTRI: r = XLEN'(ra > ib);
      OP_GTRR: r = XLEN'(ra > rb);
      OP_EQIR: r = XLEN'(ia == rb);
      OP_EQRI: r = XLEN'(ra == ib);
      default: r = XLEN'(ra == rb);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bip_progmem.sv
module bip_progmem
  import bip_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  instr_t        wdata,
  input  logic [AW-1:0] raddr,
  output instr_t        rdata
);
  instr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bip_regfile.sv
module bip_regfile
  import bip_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bind_en,
  input  logic [SW-1:0]        bind_sel,
  input  logic [XLEN-1:0]      ip,
  input  logic [FW-1:0]        rd_a_idx,
  input  logic [FW-1:0]        rd_b_idx,
  output logic [XLEN-1:0]      rd_a,
  output logic [XLEN-1:0]      rd_b,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_idx,
  input  logic [XLEN-1:0]      wr_data,
  input  logic                 cp_en,
  output logic [NREG*XLEN-1:0] regs_flat
);
  localparam logic [FW-1:0] NREG_F = FW'(NREG);

  logic [XLEN-1:0] regs [NREG];

  // Read with copy-in: the bound register shows the pointer value.
  function automatic logic [XLEN-1:0] rd(logic [FW-1:0] idx);
    if (idx >= NREG_F) return '0;
    if (bind_en && idx == FW'(bind_sel)) return ip;
    return regs[idx[SW-1:0]];
  endfunction

  assign rd_a = rd(rd_a_idx);
  assign rd_b = rd(rd_b_idx);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (clr)                               regs[g] <= '0;
      else if (wr_en && wr_idx == SW'(g))         regs[g] <= wr_data;
      else if (cp_en && bind_sel == SW'(g))       regs[g] <= ip;
    end
    assign regs_flat[g*XLEN +: XLEN] = regs[g];
  end
endmodule

// File: rtl/bip_alu.sv
module bip_alu
  import bip_pkg::*;
(
  input  instr_t          instr,
  input  logic [XLEN-1:0] rd_a,
  input  logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] result
);
  assign result = op_eval(instr.opc, rd_a, rd_b,
                          XLEN'(instr.fa), XLEN'(instr.fb));
endmodule

// File: rtl/bip_ctrl.sv
module bip_ctrl
  import bip_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            bind_en,
  input  logic [SW-1:0]   bind_sel,
  input  logic [AW:0]     prog_len,
  input  logic [FW-1:0]   dst_field,
  input  logic [XLEN-1:0] result,
  output logic [XLEN-1:0] ip,
  output logic            running,
  output logic            halted,
  output logic            start_ok,
  output logic            exec_fire,
  output logic            halt_fire,
  output logic            jump_hit,
  output logic            wr_en,
  output logic [SW-1:0]   wr_idx,
  output logic            cp_en,
  output logic            bind_en_q,
  output logic [SW-1:0]   bind_sel_q
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
  localparam logic [FW-1:0] NREG_F = FW'(NREG);

  st_e            st;
  logic [AW:0]    len_q;
  logic           in_range;
  logic [XLEN-1:0] ip_next;

  assign running   = (st == ST_RUN);
  assign halted    = (st == ST_DONE);
  assign start_ok  = start && !running;
  assign in_range  = ip < XLEN'(len_q);
  assign exec_fire = running && in_range;
  assign halt_fire = running && !in_range;
  assign jump_hit  = bind_en_q && dst_field == FW'(bind_sel_q);
  assign wr_en     = exec_fire && dst_field < NREG_F;
  assign wr_idx    = dst_field[SW-1:0];
  assign cp_en     = exec_fire && bind_en_q && !jump_hit;
  assign ip_next   = (jump_hit ? result : ip) + XLEN'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ip         <= '0;
      len_q      <= '0;
      bind_en_q  <= 1'b0;
      bind_sel_q <= '0;
    end else if (start_ok) begin
      st         <= ST_RUN;
      ip         <= '0;
      len_q      <= prog_len;
      bind_en_q  <= bind_en && (bind_sel < SW'(NREG));
      bind_sel_q <= bind_sel;
    end else if (exec_fire) begin
      ip <= ip_next;
    end else if (halt_fire) begin
      st <= ST_DONE;
    end
  end
endmodule

// File: rtl/bip_core.sv
module bip_core
  import bip_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  localparam int AW = $clog2(PROG_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 bind_en,
  input  logic [2:0]           bind_sel,
  input  logic [AW:0]          prog_len,
  input  logic                 ld_we,
  input  logic [AW-1:0]        ld_addr,
  input  logic [3:0]           ld_op,
  input  logic [15:0]          ld_a,
  input  logic [15:0]          ld_b,
  input  logic [15:0]          ld_c,
  output logic                 halted,
  output logic                 running,
  output logic [31:0]          ip,
  output logic [NREG*XLEN-1:0] regs_flat
);
  instr_t          ld_word, cur;
  logic [XLEN-1:0] rd_a, rd_b, result;
  logic            start_ok, exec_fire, halt_fire, jump_hit;
  logic            wr_en, cp_en, bind_en_q;
  logic [SW-1:0]   wr_idx, bind_sel_q;

  assign ld_word = '{opc: op_e'(ld_op), fa: ld_a, fb: ld_b, fc: ld_c};

  bip_progmem #(.DEPTH(PROG_DEPTH)) u_mem (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_word),
    .raddr(ip[AW-1:0]), .rdata(cur)
  );

  bip_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .clr(start_ok),
    .bind_en(bind_en_q), .bind_sel(bind_sel_q), .ip(ip),
    .rd_a_idx(cur.fa), .rd_b_idx(cur.fb), .rd_a(rd_a), .rd_b(rd_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(result),
    .cp_en(cp_en), .regs_flat(regs_flat)
  );

  bip_alu u_alu (.instr(cur), .rd_a(rd_a), .rd_b(rd_b), .result(result));

  bip_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bind_en(bind_en), .bind_sel(bind_sel), .prog_len(prog_len),
    .dst_field(cur.fc), .result(result), .ip(ip),
    .running(running), .halted(halted), .start_ok(start_ok),
    .exec_fire(exec_fire), .halt_fire(halt_fire), .jump_hit(jump_hit),
    .wr_en(wr_en), .wr_idx(wr_idx), .cp_en(cp_en),
    .bind_en_q(bind_en_q), .bind_sel_q(bind_sel_q)
  );
endmodule

// File: rtl/bip_core_chk.sv
module bip_core_chk
  import bip_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 halted,
  input logic                 running,
  input logic [XLEN-1:0]      ip,
  input logic [NREG*XLEN-1:0] regs_flat,
  input logic                 exec_fire,
  input logic                 halt_fire,
  input logic                 jump_hit,
  input logic                 bind_en_q,
  input logic [SW-1:0]        bind_sel_q
);
  assert_state_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && running));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> (running && ip == '0 && regs_flat == '0));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !jump_hit) |=> ip == $past(ip) + XLEN'(1));

  assert_copy_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && bind_en_q && !jump_hit)
      |=> regs_flat[bind_sel_q*XLEN +: XLEN] == $past(ip));

  assert_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && jump_hit)
      |=> ip == regs_flat[bind_sel_q*XLEN +: XLEN] + XLEN'(1));

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_fire |=> (halted && !running));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> ($stable(regs_flat) && $stable(ip) && halted));
endmodule

bind bip_core bip_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
  .running(running), .ip(ip), .regs_flat(regs_flat),
  .exec_fire(exec_fire), .halt_fire(halt_fire), .jump_hit(jump_hit),
  .bind_en_q(bind_en_q), .bind_sel_q(bind_sel_q)
);

// File: tb/bip_core_tb_top.sv
module bip_core_tb_top;
  localparam int DEPTH = 32;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bind_en = 1'b0;
  logic [2:0]    bind_sel = '0;
  logic [AW:0]   prog_len = '0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [3:0]    ld_op = '0;
  logic [15:0]   ld_a = '0, ld_b = '0, ld_c = '0;
  logic          halted, running;
  logic [31:0]   ip;
  logic [191:0]  regs_flat;

  always #2 clk = ~clk;

  bip_core #(.PROG_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bind_en(bind_en),
    .bind_sel(bind_sel), .prog_len(prog_len), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_op(ld_op), .ld_a(ld_a), .ld_b(ld_b),
    .ld_c(ld_c), .halted(halted), .running(running), .ip(ip),
    .regs_flat(regs_flat)
  );

  int errors = 0;
  int checks = 0;

  int          p_op [DEPTH];
  int          p_a  [DEPTH];
  int          p_b  [DEPTH];
  int          p_c  [DEPTH];
  logic [31:0] m_r  [6];
  logic [31:0] m_ip;
  int          m_steps;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dreg(input int k);
    return regs_flat[k*32 +: 32];
  endfunction

  task automatic put(input int idx, input int op, input int a,
                     input int b, input int c);
    p_op[idx] = op; p_a[idx] = a; p_b[idx] = b; p_c[idx] = c;
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(idx); ld_op = 4'(op);
    ld_a = 16'(a); ld_b = 16'(b); ld_c = 16'(c);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic logic [31:0] mrd(input int k);
    return (k < 6) ? m_r[k] : 32'd0;
  endfunction

  // Independent step model built from the requirements.
  task automatic model(input bit ben, input int bsel, input int len);
    for (int k = 0; k < 6; k++) m_r[k] = '0;
    m_ip = '0; m_steps = 0;
    while (m_ip < 32'(len) && m_steps < 5000) begin
      logic [31:0] va, vb, la, lb, res;
      int i;
      i = int'(m_ip);
      if (ben) m_r[bsel] = m_ip;
      la = 32'(p_a[i]); lb = 32'(p_b[i]);
      va = mrd(p_a[i]); vb = mrd(p_b[i]);
      case (p_op[i])
        0: res = va + vb;      1: res = va + lb;
        2: res = va * vb;      3: res = va * lb;
        4: res = va & vb;      5: res = va & lb;
        6: res = va | vb;      7: res = va | lb;
        8: res = va;           9: res = la;
        10: res = (la > vb) ? 1 : 0;
        11: res = (va > lb) ? 1 : 0;
        12: res = (va > vb) ? 1 : 0;
        13: res = (la == vb) ? 1 : 0;
        14: res = (va == lb) ? 1 : 0;
        default: res = (va == vb) ? 1 : 0;
      endcase
      if (p_c[i] < 6) m_r[p_c[i]] = res;
      if (ben) m_ip = m_r[bsel];
      m_ip = m_ip + 1;
      m_steps++;
    end
  endtask

  // Start a run, optionally poke start and the binding inputs mid-run.
  task automatic run_cmp(input string tag, input bit ben, input int bsel,
                         input int len, input int poke_at);
    int n;
    logic [191:0] snap;
    model(ben, bsel, len);
    @(negedge clk);
    bind_en = ben; bind_sel = 3'(bsel); prog_len = 6'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!halted && n < 20000) begin
      if (n == poke_at) begin
        start = 1'b1; bind_en = ~ben; bind_sel = 3'(5 - bsel); prog_len = 6'd31;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(tag, "cycles to halt", 32'(n), 32'(m_steps + 1));
    chk(tag, "halted", {31'd0, halted}, 32'd1);
    chk(tag, "running", {31'd0, running}, 32'd0);
    chk(tag, "ip", ip, m_ip);
    for (int k = 0; k < 6; k++) chk(tag, $sformatf("reg%0d", k), dreg(k), m_r[k]);
    snap = regs_flat;
    repeat (3) @(negedge clk);
    chk("R10", "regs frozen after halt", 32'(regs_flat == snap), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1", "regs after reset", 32'(regs_flat == '0), 32'd1);
    chk("R1", "ip after reset", ip, 32'd0);
    chk("R1", "halted after reset", {31'd0, halted}, 32'd0);
    chk("R1", "running after reset", {31'd0, running}, 32'd0);
  endtask

  task automatic t_arith;   // R3
    put(0, 9, 7, 0, 0);  put(1, 9, 5, 0, 1);  put(2, 0, 0, 1, 2);
    put(3, 1, 2, 100, 3); put(4, 2, 0, 1, 4); put(5, 9, 16'hFFFF, 0, 5);
    put(6, 2, 5, 5, 5);  put(7, 2, 5, 5, 5);  put(8, 3, 3, 16'hFFFF, 3);
    run_cmp("R3", 1'b0, 0, 9, -1);
    chk("R3", "product wraps to low 32 bits", dreg(5), 32'hFFFC0001);
    chk("R3", "add register", dreg(2), 32'd12);
  endtask

  task automatic t_bitwise;  // R4
    put(0, 9, 16'hF0F0, 0, 0); put(1, 9, 16'h0FF0, 0, 1);
    put(2, 4, 0, 1, 2); put(3, 5, 0, 16'h00FF, 3);
    put(4, 6, 0, 1, 4); put(5, 7, 1, 16'hF000, 5);
    run_cmp("R4", 1'b0, 0, 6, -1);
    chk("R4", "and register", dreg(2), 32'h00F0);
    chk("R4", "or immediate", dreg(5), 32'hFFF0);
  endtask

  task automatic t_set;      // R5: B fields carry junk
    put(0, 9, 16'h1234, 16'hBEEF, 0); put(1, 8, 0, 16'h0005, 1);
    put(2, 9, 3, 16'h0004, 2);
    run_cmp("R5", 1'b0, 0, 3, -1);
    chk("R5", "copy ignores B", dreg(1), 32'h1234);
    chk("R5", "literal ignores B", dreg(2), 32'd3);
  endtask

  task automatic t_compare;  // R6 and R7
    put(0, 9, 9, 0, 0);  put(1, 9, 9, 0, 1);
    put(2, 10, 9, 0, 2);  put(3, 11, 0, 8, 3); put(4, 12, 0, 1, 4);
    put(5, 13, 9, 0, 5);
    run_cmp("R6", 1'b0, 0, 6, -1);
    chk("R6", "lit A > rB equal gives 0", dreg(2), 32'd0);
    chk("R6", "rA > lit B gives 1", dreg(3), 32'd1);
    chk("R7", "lit A == rB gives 1", dreg(5), 32'd1);
    put(0, 9, 4, 0, 0); put(1, 9, 6, 0, 1);
    put(2, 14, 0, 5, 2); put(3, 15, 0, 1, 3); put(4, 15, 1, 1, 4);
    put(5, 12, 1, 0, 5);
    run_cmp("R7", 1'b0, 0, 6, -1);
    chk("R7", "rA == rB differing gives 0", dreg(3), 32'd0);
    chk("R7", "rA == rB same gives 1", dreg(4), 32'd1);
    chk("R6", "rA > rB gives 1", dreg(5), 32'd1);
  endtask

  task automatic t_badidx;   // R11 and R8
    put(0, 9, 9, 0, 7); put(1, 9, 3, 0, 0); put(2, 0, 6, 0, 1);
    put(3, 9, 5, 0, 6);
    run_cmp("R11", 1'b0, 0, 4, -1);
    chk("R11", "out-of-range read is zero", dreg(1), 32'd3);
    chk("R8", "ip after four steps", ip, 32'd4);
  endtask

  task automatic t_bound;    // R9 copy-in without jump
    put(0, 9, 1, 0, 0); put(1, 0, 2, 0, 4); put(2, 2, 2, 2, 5);
    run_cmp("R9", 1'b1, 2, 3, -1);
    chk("R9", "read of bound reg sees ip", dreg(4), 32'd2);
    chk("R9", "bound reg holds last ip", dreg(2), 32'd2);
  endtask

  task automatic t_loop;     // R9 jumps, R2 mid-run start ignored
    put(0, 9, 0, 0, 0); put(1, 1, 0, 1, 0); put(2, 11, 0, 4, 1);
    put(3, 0, 1, 3, 3); put(4, 9, 0, 0, 3);
    run_cmp("R2", 1'b1, 3, 5, 5);
    chk("R9", "loop counter", dreg(0), 32'd5);
  endtask

  task automatic t_jump_out; // R10 jump beyond length
    put(0, 9, 100, 0, 0); put(1, 9, 7, 0, 1);
    run_cmp("R10", 1'b1, 0, 2, -1);
    chk("R10", "instruction past jump not run", dreg(1), 32'd0);
    chk("R10", "ip after jump out", ip, 32'd101);
  endtask

  task automatic t_restart;  // R2 restart clears registers
    run_cmp("R2", 1'b0, 0, 0, -1);
    chk("R2", "regs cleared by restart", 32'(regs_flat == '0), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_bitwise();
    t_set();
    t_compare();
    t_badidx();
    t_bound();
    t_loop();
    t_jump_out();
    t_restart();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule